// File: doc/BRIEF.md
# DMA Channel Request Front End

This block sits in front of one channel of a DMA engine and decides when that channel has a transfer request to present to the channel arbiter. Sixteen hardware request lines come in, and a 4-bit selector picks one of them. The selected line passes through a rising-edge detector. Each low-to-high change therefore counts as one request, however long the line then stays high. Hardware requests pass only while a hardware-enable flag is set. A software request strobe is ORed with the gated hardware request.

Any accepted request sets a pending flag, which goes to the arbiter. The pending flag is cleared by a completion event. A mode input selects the event: the end of every transfer, or only the end of the whole transaction. If a request arrives while the pending flag is still set, a sticky lost-request flag is raised, and it can drive an interrupt. In single mode, the hardware-enable flag clears itself at the end of a transaction, so the channel accepts no more hardware requests until software enables them again. A suspend request output is active when suspend is enabled and hardware requests are enabled.

Top module: `dma_chreq_ctrl`

## Requirements
- R1: `sel_i` chooses which bit of `hw_req_i` is watched (bit index equals the value of `sel_i`). Edges on every other line have no effect.
- R2: A rising edge on the selected line, with hardware requests enabled, sets `pend_o` at the second rising clock edge after the line goes high. A line that stays high makes only that one request.
- R3: After reset, `pend_o`, `hwen_o`, `lost_o` and `susp_req_o` are 0. A selected line that is already high when reset is released makes no request.
- R4: While `hwen_o` is 0, hardware request edges have no effect on `pend_o` or `lost_o`.
- R5: `hwen_set_i` sets `hwen_o` one cycle later and `hwen_clr_i` clears it. If both are high in the same cycle, the result is 0.
- R6: With `single_i`=1, `txn_done_i` clears `hwen_o`. With `single_i`=0, `txn_done_i` leaves `hwen_o` unchanged.
- R7: `sw_req_i` sets `pend_o` one cycle later, whatever the value of `hwen_o`.
- R8: With `clr_mode_i`=1, either `xfer_done_i` or `txn_done_i` clears `pend_o`. With `clr_mode_i`=0, only `txn_done_i` clears it, and `xfer_done_i` is ignored.
- R9: A request that arrives while `pend_o` is 1, with no clear event in that cycle, sets `lost_o`. `lost_o` then stays 1 and `pend_o` stays 1.
- R10: `err_clr_i` clears `lost_o`. It wins over a lost request in the same cycle.
- R11: A request in the same cycle as a clear event leaves `pend_o` at 1 and does not set `lost_o`.
- R12: `ch_rst_i` clears `pend_o` and `hwen_o`. It wins over a request or `hwen_set_i` in the same cycle, and that request does not set `lost_o`.
- R13: `susp_req_o` equals the AND of `susp_en_i` and `hwen_o`, delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_i | input | 16 | Hardware request lines |
| sel_i | input | 4 | Index of the line that is watched |
| hwen_set_i | input | 1 | Enable hardware requests (strobe) |
| hwen_clr_i | input | 1 | Disable hardware requests (strobe) |
| sw_req_i | input | 1 | Software request (strobe) |
| single_i | input | 1 | 1 = single mode (enable clears at end of transaction) |
| clr_mode_i | input | 1 | 1 = clear pending at end of each transfer, 0 = only at end of transaction |
| xfer_done_i | input | 1 | End of one transfer |
| txn_done_i | input | 1 | End of the transaction |
| ch_rst_i | input | 1 | Channel reset strobe |
| err_clr_i | input | 1 | Clear the lost-request flag (write one) |
| susp_en_i | input | 1 | Suspend enable |
| pend_o | output | 1 | Pending request to the arbiter |
| hwen_o | output | 1 | Hardware requests enabled |
| lost_o | output | 1 | Sticky lost-request flag |
| susp_req_o | output | 1 | Suspend request |

## Verification
The hardest situations to reach are collisions: a request that lands in the same cycle as a clear event, a channel reset or an error clear. A hardware edge in one of these cycles has to be lined up two clocks ahead, through the selector and the edge detector. The directed part uses the software strobe to force each collision exactly, and checks the result against hand-computed values. The random part toggles the request lines and all the strobes at a high rate, so edges meet every clear event and the enable changes many times. A cycle model built from the requirements checks every output in every cycle.

// File: rtl/dma_chreq_pkg.sv
package dma_chreq_pkg;
  typedef enum logic {
    CLR_AT_TXN  = 1'b0,
    CLR_AT_XFER = 1'b1
  } clr_sel_e;
endpackage

// File: rtl/dma_chreq_sel.sv
module dma_chreq_sel #(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 line_o
);
  // Register the picked line. Reset to 1 so a line that is already high at reset release gives no edge.
  always_ff @(posedge clk) begin
    if (rst) line_o <= 1'b1;
    else     line_o <= lines_i[sel_i];
  end
endmodule

// File: rtl/dma_chreq_edge.sv
module dma_chreq_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic pulse_o
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b1;
    else     hist_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~hist_q;

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/dma_chreq_hwen.sv
module dma_chreq_hwen (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ch_rst_i,
  input  logic single_i,
  input  logic txn_done_i,
  output logic hwen_o
);
  logic kill;
  assign kill = clr_i | ch_rst_i | (single_i & txn_done_i);

  always_ff @(posedge clk) begin
    if (rst)        hwen_o <= 1'b0;
    else if (kill)  hwen_o <= 1'b0;
    else if (set_i) hwen_o <= 1'b1;
  end

  assert_clr_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i) |=> !hwen_o);
  assert_single_autoclr_R6: assert property (@(posedge clk) disable iff (rst)
    (single_i && txn_done_i) |=> !hwen_o);
  assert_chrst_hwen_R12: assert property (@(posedge clk) disable iff (rst)
    ch_rst_i |=> !hwen_o);
endmodule

// File: rtl/dma_chreq_pend.sv
module dma_chreq_pend
  import dma_chreq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_i,
  input  clr_sel_e mode_i,
  input  logic     xfer_done_i,
  input  logic     txn_done_i,
  input  logic     ch_rst_i,
  input  logic     err_clr_i,
  output logic     pend_o,
  output logic     lost_o
);
  logic clr_evt, overrun;

  assign clr_evt = txn_done_i | ((mode_i == CLR_AT_XFER) & xfer_done_i);
  assign overrun = req_i & pend_o & ~clr_evt & ~ch_rst_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      lost_o <= 1'b0;
    end else begin
      if (ch_rst_i)     pend_o <= 1'b0;
      else if (req_i)   pend_o <= 1'b1;
      else if (clr_evt) pend_o <= 1'b0;

      if (err_clr_i)    lost_o <= 1'b0;
      else if (overrun) lost_o <= 1'b1;
    end
  end

  assert_req_sets_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (req_i && !ch_rst_i) |=> pend_o);
  assert_lost_on_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    (req_i && pend_o && !clr_evt && !ch_rst_i && !err_clr_i) |=> lost_o);
  assert_err_clr_wins_R10: assert property (@(posedge clk) disable iff (rst)
    err_clr_i |=> !lost_o);
  assert_chrst_clears_R12: assert property (@(posedge clk) disable iff (rst)
    ch_rst_i |=> !pend_o);
endmodule

// File: rtl/dma_chreq_ctrl.sv
module dma_chreq_ctrl
  import dma_chreq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] hw_req_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 hwen_set_i,
  input  logic                 hwen_clr_i,
  input  logic                 sw_req_i,
  input  logic                 single_i,
  input  logic                 clr_mode_i,
  input  logic                 xfer_done_i,
  input  logic                 txn_done_i,
  input  logic                 ch_rst_i,
  input  logic                 err_clr_i,
  input  logic                 susp_en_i,
  output logic                 pend_o,
  output logic                 hwen_o,
  output logic                 lost_o,
  output logic                 susp_req_o
);
  logic picked, hw_pulse, req;

  dma_chreq_sel #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .lines_i(hw_req_i), .sel_i(sel_i), .line_o(picked));

  dma_chreq_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(picked), .pulse_o(hw_pulse));

  dma_chreq_hwen u_hwen (
    .clk(clk), .rst(rst), .set_i(hwen_set_i), .clr_i(hwen_clr_i),
    .ch_rst_i(ch_rst_i), .single_i(single_i), .txn_done_i(txn_done_i),
    .hwen_o(hwen_o));

  assign req = (hw_pulse & hwen_o) | sw_req_i;

  dma_chreq_pend u_pend (
    .clk(clk), .rst(rst), .req_i(req), .mode_i(clr_sel_e'(clr_mode_i)),
    .xfer_done_i(xfer_done_i), .txn_done_i(txn_done_i), .ch_rst_i(ch_rst_i),
    .err_clr_i(err_clr_i), .pend_o(pend_o), .lost_o(lost_o));

  always_ff @(posedge clk) begin
    if (rst) susp_req_o <= 1'b0;
    else     susp_req_o <= susp_en_i & hwen_o;
  end

  assert_susp_follow_R13: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (susp_req_o == $past(susp_en_i && hwen_o)));
  assert_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!hwen_o && !sw_req_i && !pend_o) |=> !pend_o);
endmodule

// File: tb/dma_chreq_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chreq_ctrl_bench;
  logic clk = 0, rst = 1;
  logic [15:0] hw_req = 0;
  logic [3:0] sel = 0;
  logic hset = 0, hclr = 0, sw = 0, single = 0, mode = 0;
  logic xfer = 0, txn = 0, chrst = 0, eclr = 0, susp_en = 0;
  logic pend, hwen, lost, susp;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dma_chreq_ctrl u_dma_chreq_ctrl (
    .clk(clk), .rst(rst), .hw_req_i(hw_req), .sel_i(sel), .hwen_set_i(hset),
    .hwen_clr_i(hclr), .sw_req_i(sw), .single_i(single), .clr_mode_i(mode),
    .xfer_done_i(xfer), .txn_done_i(txn), .ch_rst_i(chrst), .err_clr_i(eclr),
    .susp_en_i(susp_en), .pend_o(pend), .hwen_o(hwen), .lost_o(lost),
    .susp_req_o(susp));

  // Reference model built from the requirements
  logic m_cur, m_prev, m_hwen, m_pend, m_lost, m_susp;
  function automatic logic f_req(logic cur, logic prev, logic en, logic s);
    return (cur & ~prev & en) | s;
  endfunction
  function automatic logic f_clr(logic md, logic xd, logic td);
    return td | (md & xd);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cur <= 1; m_prev <= 1; m_hwen <= 0; m_pend <= 0; m_lost <= 0; m_susp <= 0;
    end else begin
      logic r, c;
      r = f_req(m_cur, m_prev, m_hwen, sw);
      c = f_clr(mode, xfer, txn);
      m_pend <= chrst ? 1'b0 : (r | (m_pend & ~c));
      m_lost <= eclr ? 1'b0 : (m_lost | (r & m_pend & ~c & ~chrst));
      m_hwen <= (chrst | hclr | (single & txn)) ? 1'b0 : (hset ? 1'b1 : m_hwen);
      m_susp <= susp_en & m_hwen;
      m_prev <= m_cur;
      m_cur  <= hw_req[sel];
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    check(pend, m_pend, "model pend R1 R2 R7 R8 R11");
    check(hwen, m_hwen, "model hwen R5 R6 R12");
    check(lost, m_lost, "model lost R9 R10");
    check(susp, m_susp, "model susp R13");
  endtask

  task automatic idle();
    hset = 0; hclr = 0; sw = 0; xfer = 0; txn = 0; chrst = 0; eclr = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    if (!rst) cmp_model();
    idle();
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    hw_req = 16'hFFFF;
    @(negedge clk); tick(); tick();
    rst = 0;
    check(pend, 0, "R3 reset pend"); check(hwen, 0, "R3 reset hwen");
    check(lost, 0, "R3 reset lost"); check(susp, 0, "R3 reset susp");
    hset = 1; tick(); tick(); tick(); tick();
    check(pend, 0, "R3 line high at reset release");
    // R1 / R2
    sel = 5; hw_req = 0; tick(); tick();
    hw_req[3] = 1; tick(); tick(); tick();
    check(pend, 0, "R1 unselected line ignored");
    hw_req[5] = 1; tick();
    check(pend, 0, "R2 one edge latency");
    tick();
    check(pend, 1, "R1 selected edge sets pend");
    txn = 1; tick();
    check(pend, 0, "R8 txn clears pend");
    tick(); tick(); tick();
    check(pend, 0, "R2 held level no repeat"); check(lost, 0, "R2 no lost");
    // R4
    hclr = 1; tick();
    check(hwen, 0, "R5 clear");
    hw_req[5] = 0; tick(); hw_req[5] = 1; tick(); tick(); tick();
    check(pend, 0, "R4 gated edge ignored"); check(lost, 0, "R4 no lost");
    // R7 R9 R10
    sw = 1; tick();
    check(pend, 1, "R7 sw sets pend");
    sw = 1; tick();
    check(lost, 1, "R9 overrun sets lost"); check(pend, 1, "R9 pend stays");
    eclr = 1; sw = 1; tick();
    check(lost, 0, "R10 clear wins");
    // R8
    mode = 0; xfer = 1; tick();
    check(pend, 1, "R8 xfer ignored in txn mode");
    mode = 1; xfer = 1; tick();
    check(pend, 0, "R8 xfer clears in xfer mode");
    // R11
    sw = 1; tick();
    sw = 1; txn = 1; tick();
    check(pend, 1, "R11 req with clear keeps pend"); check(lost, 0, "R11 no lost");
    // R12 R5
    hset = 1; tick();
    chrst = 1; sw = 1; hset = 1; tick();
    check(pend, 0, "R12 pend"); check(hwen, 0, "R12 hwen"); check(lost, 0, "R12 lost");
    hset = 1; hclr = 1; tick();
    check(hwen, 0, "R5 clear wins");
    hset = 1; tick();
    check(hwen, 1, "R5 set");
    // R6
    single = 1; txn = 1; tick();
    check(hwen, 0, "R6 single autoclear");
    hset = 1; tick();
    single = 0; txn = 1; tick();
    check(hwen, 1, "R6 continuous keeps");
    // R13
    susp_en = 1; tick();
    check(susp, 1, "R13 susp on");
    hclr = 1; tick();
    check(susp, 1, "R13 delayed");
    tick();
    check(susp, 0, "R13 susp off");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) hw_req = 16'($urandom);
      if ($urandom_range(31) == 0) sel = 4'($urandom);
      if ($urandom_range(63) == 0) begin single = 1'($urandom); mode = 1'($urandom); end
      susp_en = 1'($urandom);
      hset  = ($urandom_range(5) == 0);
      hclr  = ($urandom_range(11) == 0);
      sw    = ($urandom_range(9) == 0);
      xfer  = ($urandom_range(5) == 0);
      txn   = ($urandom_range(11) == 0);
      chrst = ($urandom_range(39) == 0);
      eclr  = ($urandom_range(15) == 0);
      tick();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule